// File: doc/BRIEF.md
# I/O Window Register Set with Doorbell Interrupt

This block serves a 32-byte window of I/O-mapped registers. The base of the window and a decode-enable bit come from the device's configuration logic. Each cycle, at most one I/O request is presented with an address and a read/write flag. A request that lands inside the enabled window is acknowledged one cycle later. A read also returns its data in that cycle. Requests outside the window get no acknowledge and change nothing.

The window returns four fixed identification bytes and a mirror of the interrupt line and interrupt pin values held by the configuration logic. It also holds a doorbell register. A write of any value to the doorbell marks an interrupt as pending, and a registered, active-high level interrupt output follows the pending flag. A read of the doorbell returns the flag and clears it, which lets software acknowledge the interrupt. Every register is one byte wide, so read data is that byte zero-extended to the full bus width. Write data carries no meaning and is therefore not an input.

Top module: `io_window_regs`

## Requirements
- R1: A request hits when `req_valid` is high, `dec_en` is high and `req_addr[15:5]` equals `win_base`. A hit raises `rsp_ack` in the following cycle. Any other cycle leaves `rsp_ack` low in the following cycle.
- R2: A hitting read at window offsets 0, 1, 2 and 3 returns 0x1A, 0x07, 0x0B and 0xAB respectively.
- R3: A hitting read at offset 4 returns `irq_line` as sampled in the request cycle. A hitting read at offset 5 returns `irq_pin` as sampled in the request cycle.
- R4: A hitting write at offset 6 sets the pending flag. `irq_out` is high two cycles after the request cycle.
- R5: A hitting read at offset 6 returns the pending flag in bit 0 (1 or 0) and clears the flag. `irq_out` is low two cycles after that request cycle.
- R6: Hitting reads at offsets 7 through 31 return 0. Hitting writes at any offset other than 6 leave the pending flag and `irq_out` unchanged.
- R7: `rsp_rdata[31:8]` is always 0. `rsp_rdata` is 0 in every cycle that does not carry a read acknowledge.
- R8: After reset, `rsp_ack`, `rsp_rdata` and `irq_out` are 0 and the pending flag is clear.
- R9: A write to offset 6 that does not hit has no effect, whether the miss comes from `dec_en` low or from a different base.
- R10: A write to offset 6 while the flag is already pending keeps it pending. A single doorbell read then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | I/O decode enable from configuration logic |
| win_base | input | 11 | Window base, address bits [15:5] |
| irq_line | input | 8 | Interrupt line value to mirror |
| irq_pin | input | 8 | Interrupt pin value to mirror |
| req_valid | input | 1 | I/O request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O byte address |
| rsp_ack | output | 1 | Acknowledge, one cycle after a hit |
| rsp_rdata | output | 32 | Read data, zero-extended byte |
| irq_out | output | 1 | Level interrupt, active high |

## Verification
Two things can happen in the same cycle: the doorbell read clears the pending flag, and the interrupt register samples that flag. The bench provokes this with a doorbell write followed at once by a doorbell read. It expects the read to return 1 and `irq_out` to stay high for exactly one cycle before falling. A cycle-accurate behavioural model in the bench predicts acknowledge, read data and the interrupt level every clock. It also covers repeated writes while pending and doorbell writes that miss the window.

// File: rtl/io_win_pkg.sv
package io_win_pkg;

    localparam int ADDR_W   = 16;
    localparam int WIN_LOG2 = 5;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;

    // Identification bytes, offset 0 in the least significant byte
    localparam logic [4*BYTE_W-1:0] ID_BYTES = 32'hAB0B_071A;

    // Window offsets whose meaning is fixed by behaviour
    localparam int OFS_LINE = 4;
    localparam int OFS_PIN  = 5;
    localparam int OFS_BELL = 6;

    typedef enum logic [2:0] {
        SRC_ZERO = 3'd0,
        SRC_ID   = 3'd1,
        SRC_LINE = 3'd2,
        SRC_PIN  = 3'd3,
        SRC_BELL = 3'd4
    } rd_src_e;

    typedef struct packed {
        logic    hit;
        logic    is_read;
        rd_src_e src;
        logic [1:0] id_sel;
    } win_access_t;

    function automatic logic [BYTE_W-1:0] id_byte(input logic [1:0] sel);
        return ID_BYTES[sel*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/io_win_decode.sv
module io_win_decode
    import io_win_pkg::*;
#(
    parameter int P_ADDR_W   = io_win_pkg::ADDR_W,
    parameter int P_WIN_LOG2 = io_win_pkg::WIN_LOG2,
    localparam int BASE_W    = P_ADDR_W - P_WIN_LOG2
) (
    input  logic                dec_en,
    input  logic [BASE_W-1:0]   win_base,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [P_ADDR_W-1:0] req_addr,
    output win_access_t         acc,
    output logic                bell_set,
    output logic                bell_clr
);

    logic [P_WIN_LOG2-1:0] ofs;
    logic                  hit;
    logic                  at_bell;

    assign ofs     = req_addr[P_WIN_LOG2-1:0];
    assign hit     = req_valid && dec_en && (req_addr[P_ADDR_W-1:P_WIN_LOG2] == win_base);
    assign at_bell = (ofs == P_WIN_LOG2'(OFS_BELL));

    always_comb begin
        acc.hit     = hit;
        acc.is_read = hit && !req_write;
        acc.id_sel  = ofs[1:0];
        if (ofs < P_WIN_LOG2'(4))                  acc.src = SRC_ID;
        else if (ofs == P_WIN_LOG2'(OFS_LINE))     acc.src = SRC_LINE;
        else if (ofs == P_WIN_LOG2'(OFS_PIN))      acc.src = SRC_PIN;
        else if (at_bell)                          acc.src = SRC_BELL;
        else                                       acc.src = SRC_ZERO;
    end

    assign bell_set = hit &&  req_write && at_bell;
    assign bell_clr = hit && !req_write && at_bell;

endmodule

// File: rtl/io_win_doorbell.sv
module io_win_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic bell_set,
    input  logic bell_clr,
    output logic pending,
    output logic irq_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (bell_set) begin
            pending <= 1'b1;
        end else if (bell_clr) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= pending;
    end

endmodule

// File: rtl/io_win_resp.sv
module io_win_resp
    import io_win_pkg::*;
#(
    parameter int P_DATA_W = io_win_pkg::DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  win_access_t         acc,
    input  logic [BYTE_W-1:0]   line_val,
    input  logic [BYTE_W-1:0]   pin_val,
    input  logic                pending,
    output logic                rsp_ack,
    output logic [P_DATA_W-1:0] rsp_rdata
);

    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        unique case (acc.src)
            SRC_ID:   rd_byte = id_byte(acc.id_sel);
            SRC_LINE: rd_byte = line_val;
            SRC_PIN:  rd_byte = pin_val;
            SRC_BELL: rd_byte = {{(BYTE_W-1){1'b0}}, pending};
            default:  rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= acc.hit;
            rsp_rdata <= acc.is_read ? P_DATA_W'(rd_byte) : '0;
        end
    end

endmodule

// File: rtl/io_window_regs.sv
module io_window_regs
    import io_win_pkg::*;
#(
    parameter int ADDR_W   = io_win_pkg::ADDR_W,
    parameter int WIN_LOG2 = io_win_pkg::WIN_LOG2,
    parameter int DATA_W   = io_win_pkg::DATA_W,
    localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_en,
    input  logic [BASE_W-1:0] win_base,
    input  logic [7:0]        irq_line,
    input  logic [7:0]        irq_pin,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_out
);

    win_access_t acc;
    logic        bell_set;
    logic        bell_clr;
    logic        pending;

    io_win_decode #(
        .P_ADDR_W   (ADDR_W),
        .P_WIN_LOG2 (WIN_LOG2)
    ) u_decode (
        .dec_en    (dec_en),
        .win_base  (win_base),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .acc       (acc),
        .bell_set  (bell_set),
        .bell_clr  (bell_clr)
    );

    io_win_doorbell u_bell (
        .clk      (clk),
        .rst      (rst),
        .bell_set (bell_set),
        .bell_clr (bell_clr),
        .pending  (pending),
        .irq_out  (irq_out)
    );

    io_win_resp #(
        .P_DATA_W (DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .line_val  (irq_line),
        .pin_val   (irq_pin),
        .pending   (pending),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/io_win_checker.sv
module io_win_checker #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 5,
    parameter int DATA_W   = 32,
    localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_en,
    input logic [BASE_W-1:0] win_base,
    input logic [7:0]        irq_line,
    input logic [7:0]        irq_pin,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_ack,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_out
);

    logic in_win;
    assign in_win = req_valid && dec_en && (req_addr[ADDR_W-1:WIN_LOG2] == win_base);

    logic [WIN_LOG2-1:0] off;
    assign off = req_addr[WIN_LOG2-1:0];

    p_ack_on_hit_r1: assert property (@(posedge clk) disable iff (rst)
        in_win |=> rsp_ack);

    p_no_ack_on_miss_r1: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> !rsp_ack);

    p_id_first_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (in_win && !req_write && off == '0) |=> (rsp_rdata == DATA_W'(8'h1A)));

    p_line_mirror_r3: assert property (@(posedge clk) disable iff (rst)
        (in_win && !req_write && off == WIN_LOG2'(4)) |=> (rsp_rdata == DATA_W'($past(irq_line))));

    p_bell_raises_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (in_win && req_write && off == WIN_LOG2'(6)) |=> ##1 irq_out);

    p_bell_read_drops_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (in_win && !req_write && off == WIN_LOG2'(6)) |=> ##1 !irq_out);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_rdata[DATA_W-1:8] == '0);

    p_idle_data_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rsp_ack |-> (rsp_rdata == '0));

endmodule

bind io_window_regs io_win_checker #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .DATA_W   (DATA_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .dec_en    (dec_en),
    .win_base  (win_base),
    .irq_line  (irq_line),
    .irq_pin   (irq_pin),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .irq_out   (irq_out)
);

// File: tb/io_window_regs_bench.sv
`timescale 1ns/1ps
module io_window_regs_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_en;
    logic [10:0] win_base;
    logic [7:0]  irq_line;
    logic [7:0]  irq_pin;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    bit          m_pend;
    bit          m_ack;
    logic [31:0] m_data;
    bit          m_irq;
    byte unsigned ids [4] = '{8'h1A, 8'h07, 8'h0B, 8'hAB};

    always #2.5 clk = ~clk;

    io_window_regs u_io_window_regs (
        .clk       (clk),
        .rst       (rst),
        .dec_en    (dec_en),
        .win_base  (win_base),
        .irq_line  (irq_line),
        .irq_pin   (irq_pin),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_read(input int ofs);
        if (ofs < 4)        return {24'h0, ids[ofs]};
        else if (ofs == 4)  return {24'h0, irq_line};
        else if (ofs == 5)  return {24'h0, irq_pin};
        else if (ofs == 6)  return {31'h0, m_pend};
        return 32'h0;
    endfunction

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit v, input bit w, input logic [15:0] a, input string tag);
        bit hit;
        int ofs;
        req_valid = v;
        req_write = w;
        req_addr  = a;
        @(posedge clk);
        hit = v && dec_en && (a[15:5] == win_base);
        ofs = int'(a[4:0]);
        m_irq  = m_pend;
        m_ack  = hit;
        m_data = (hit && !w) ? ref_read(ofs) : 32'h0;
        if (hit && ofs == 6) m_pend = w;
        @(negedge clk);
        check(tag, "ack",   {31'h0, rsp_ack}, {31'h0, m_ack});
        check(tag, "rdata", rsp_rdata, m_data);
        check(tag, "irq",   {31'h0, irq_out}, {31'h0, m_irq});
    endtask

    localparam logic [15:0] BASE = 16'hC040;

    initial begin
        rst = 1'b1; dec_en = 1'b1; win_base = BASE[15:5];
        irq_line = 8'h0B; irq_pin = 8'h04;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        check("R8", "ack",   {31'h0, rsp_ack}, 32'h0);
        check("R8", "rdata", rsp_rdata, 32'h0);
        check("R8", "irq",   {31'h0, irq_out}, 32'h0);
        rst = 1'b0;
        m_pend = 0;

        cyc(0, 0, BASE, "R8");
        for (int i = 0; i < 4; i++) cyc(1, 0, BASE + 16'(i), "R2");
        cyc(1, 0, BASE + 16'd4, "R3");
        cyc(1, 0, BASE + 16'd5, "R3");
        irq_line = 8'h5C; irq_pin = 8'h01;
        cyc(1, 0, BASE + 16'd4, "R3");
        cyc(1, 0, BASE + 16'd5, "R3");
        cyc(1, 0, BASE + 16'd6, "R5");
        cyc(1, 1, BASE + 16'd6, "R4");
        cyc(0, 0, BASE, "R4");
        cyc(0, 0, BASE, "R4");
        cyc(1, 0, BASE + 16'd6, "R5");
        cyc(0, 0, BASE, "R5");
        cyc(1, 0, BASE + 16'd6, "R5");
        cyc(1, 1, BASE + 16'd6, "R10");
        cyc(1, 1, BASE + 16'd6, "R10");
        cyc(0, 0, BASE, "R10");
        cyc(1, 0, BASE + 16'd6, "R10");
        cyc(1, 0, BASE + 16'd6, "R10");
        for (int i = 7; i < 32; i += 6) cyc(1, 1, BASE + 16'(i), "R6");
        cyc(1, 1, BASE + 16'd4, "R6");
        cyc(1, 0, BASE + 16'd6, "R6");
        for (int i = 7; i < 32; i += 4) cyc(1, 0, BASE + 16'(i), "R6");
        cyc(1, 0, BASE + 16'd31, "R7");
        dec_en = 1'b0;
        cyc(1, 1, BASE + 16'd6, "R9");
        cyc(1, 0, BASE + 16'd0, "R1");
        dec_en = 1'b1;
        cyc(1, 1, BASE + 16'h0026, "R9");
        cyc(1, 1, BASE - 16'h001A, "R9");
        cyc(1, 0, BASE + 16'd6, "R9");
        // Collision: clear by read right after doorbell write
        cyc(1, 1, BASE + 16'd6, "R4");
        cyc(1, 0, BASE + 16'd6, "R5");
        cyc(0, 0, BASE, "R5");
        cyc(0, 0, BASE, "R5");
        win_base = 11'h123;
        cyc(1, 0, {11'h123, 5'd3}, "R1");
        cyc(1, 0, BASE + 16'd3, "R1");
        cyc(1, 1, {11'h123, 5'd6}, "R4");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pend = 0;
        check("R8", "irq",   {31'h0, irq_out}, 32'h0);
        check("R8", "ack",   {31'h0, rsp_ack}, 32'h0);
        cyc(1, 0, {11'h123, 5'd6}, "R8");
        cyc(0, 0, BASE, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule